// File: doc/BRIEF.md
# Background Byte Memory Tester

This block sits between a functional requester and a single-port byte-wide RAM. While traffic keeps running, it checks the RAM one location at a time. It does not destroy data. On each test step it takes exclusive use of the RAM and reads the location into a holding register. It then writes and reads back four fixed patterns, and at the end it writes the held value back. The requester sees only a short stall, and the RAM contents after the step match what was there before it.

Steps are spaced by a programmable idle interval. Each step visits the next address in a fixed window, and the pointer wraps to the start of the window after the last address. A failed readback does not stop the step, and the original data is still restored. A sticky error flag then reports the address and the pattern of the first failure since the last clear. The functional port is a valid/ready request channel. A request is taken on a clock edge where `f_valid` and `f_ready` are both high. Once `f_valid` is raised, the requester holds it and the request fields steady until that edge. The block may hold `f_ready` low for a whole test step, and it never drops a request.

Top module: `mem_bg_tester`

## Requirements
- R1: Steps visit addresses `RANGE_FIRST` to `RANGE_LAST` in ascending order, one address per step, and the address after `RANGE_LAST` is `RANGE_FIRST`.
- R2: A step holds the RAM for exactly 15 consecutive cycles, and `f_ready` is low in every one of them.
- R3: The first RAM operation of a step is a read of the location under test, and it comes before any test write.
- R4: The step writes the patterns 0x00, 0xFF, 0xAA and 0x55 in that order. Each write is followed on the next cycle by a read of the same address, and then by an idle compare cycle.
- R5: The last cycle of a step writes the held original value back, so data written through the functional port reads back unchanged.
- R6: A readback that differs from its pattern sets `err_flag` at the end of the step, and the restore still takes place. The first failure since the last clear fixes `err_addr` and `err_pat` (0 for 0x00, 1 for 0xFF, 2 for 0xAA, 3 for 0x55). Later failures do not overwrite them, and the flag stays set.
- R7: `err_clr` high for one cycle outside a failing restore clears `err_flag`.
- R8: A step starts only when `enable` is high, `f_valid` is low and the interval has expired. With no traffic and `enable` steady, consecutive steps are separated by exactly `interval`+1 cycles with `f_ready` high.
- R9: A request made during a step is held with `f_ready` low and served after the step. A read accepted on one edge returns `f_rdata` with `f_rvalid` high in the following cycle.
- R10: If `enable` falls during a step, that step still runs through its restore, and no further step starts.
- R11: `pass_done` is a one-cycle pulse in the restore cycle of the step at `RANGE_LAST`, and it does not appear at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new test steps to start |
| interval | input | IW | Idle cycles before the next step may start |
| err_clr | input | 1 | Clears the sticky error flag |
| f_valid | input | 1 | Functional request valid |
| f_ready | output | 1 | Functional request accepted when high with f_valid |
| f_we | input | 1 | Functional request is a write |
| f_addr | input | AW | Functional request address |
| f_wdata | input | 8 | Functional write data |
| f_rvalid | output | 1 | Functional read data valid |
| f_rdata | output | 8 | Functional read data |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the read |
| err_flag | output | 1 | Sticky test failure flag |
| err_addr | output | AW | Address of the first captured failure |
| err_pat | output | 2 | Pattern index of the first captured failure |
| pass_done | output | 1 | Pulse when the window has been fully covered |

## Verification
The properties assume a RAM whose read data arrives exactly one cycle after the read. They also assume that `interval` changes only while `enable` is low. The step-gap and interval rules rely on that, because the properties treat a step's timing as fixed. The bench's RAM model meets the latency rule by construction. The bench changes `interval` only with `enable` deasserted, and it changes fault injection only at read time, so the tested patterns stay as defined. Functional requests follow the hold rule: each request's fields stay steady from the raise of `f_valid` until the accepting edge, including while a step is stalling it.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned NUM_PATS    = 4;
  localparam int unsigned PIDX_W      = $clog2(NUM_PATS);
  // save read, capture, three cycles per pattern, restore
  localparam int unsigned STEP_CYCLES = 3 + 3 * NUM_PATS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE_RD,
    ST_SAVE_CAP,
    ST_PAT_WR,
    ST_PAT_RD,
    ST_PAT_CMP,
    ST_RESTORE
  } mbt_state_e;

  function automatic logic [BYTE_W-1:0] pat_value(input logic [PIDX_W-1:0] idx);
    logic [BYTE_W-1:0] v;
    case (idx)
      2'd0:    v = '0;
      2'd1:    v = '1;
      2'd2:    v = {(BYTE_W/2){2'b10}};
      default: v = {(BYTE_W/2){2'b01}};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mbt_timer.sv
module mbt_timer #(
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en,
  input  logic [IW-1:0] interval,
  output logic          due
);

  logic [IW-1:0] cnt;

  assign due = (cnt >= interval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!count_en) begin
      cnt <= '0;
    end else if (!due) begin
      cnt <= cnt + IW'(1);
    end
  end

endmodule

// File: rtl/mbt_engine.sv
module mbt_engine
  import mbt_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned FIRST = 0,
  parameter int unsigned LAST  = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic              err_clr,
  output logic              active,
  output logic              m_en,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [BYTE_W-1:0] m_wdata,
  output logic              err_flag,
  output logic [AW-1:0]     err_addr,
  output logic [PIDX_W-1:0] err_pat,
  output logic              pass_done
);

  localparam logic [AW-1:0]     FIRST_A  = AW'(FIRST);
  localparam logic [AW-1:0]     LAST_A   = AW'(LAST);
  localparam logic [PIDX_W-1:0] PIDX_END = PIDX_W'(NUM_PATS - 1);

  mbt_state_e          state;
  logic [PIDX_W-1:0]   pidx;
  logic [AW-1:0]       ptr;
  logic [BYTE_W-1:0]   saved;
  logic                fail_seen;
  logic [PIDX_W-1:0]   fail_idx;
  logic                at_end;

  assign at_end = (ptr == LAST_A);

  // sequencing of one step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pidx      <= '0;
      ptr       <= FIRST_A;
      saved     <= '0;
      fail_seen <= 1'b0;
      fail_idx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_SAVE_RD;
            pidx      <= '0;
            fail_seen <= 1'b0;
          end
        end
        ST_SAVE_RD:  state <= ST_SAVE_CAP;
        ST_SAVE_CAP: begin
          saved <= rd_data;
          state <= ST_PAT_WR;
        end
        ST_PAT_WR:   state <= ST_PAT_RD;
        ST_PAT_RD:   state <= ST_PAT_CMP;
        ST_PAT_CMP: begin
          if ((rd_data != pat_value(pidx)) && !fail_seen) begin
            fail_seen <= 1'b1;
            fail_idx  <= pidx;
          end
          if (pidx == PIDX_END) begin
            state <= ST_RESTORE;
          end else begin
            pidx  <= pidx + PIDX_W'(1);
            state <= ST_PAT_WR;
          end
        end
        ST_RESTORE: begin
          state <= ST_IDLE;
          ptr   <= at_end ? FIRST_A : ptr + AW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // sticky error capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_addr <= '0;
      err_pat  <= '0;
    end else if (state == ST_RESTORE && fail_seen) begin
      err_flag <= 1'b1;
      if (!err_flag || err_clr) begin
        err_addr <= ptr;
        err_pat  <= fail_idx;
      end
    end else if (err_clr) begin
      err_flag <= 1'b0;
    end
  end

  // RAM command for the current cycle
  always_comb begin
    active    = (state != ST_IDLE);
    m_en      = (state == ST_SAVE_RD) || (state == ST_PAT_WR) ||
                (state == ST_PAT_RD)  || (state == ST_RESTORE);
    m_we      = (state == ST_PAT_WR)  || (state == ST_RESTORE);
    m_addr    = ptr;
    m_wdata   = (state == ST_RESTORE) ? saved : pat_value(pidx);
    pass_done = (state == ST_RESTORE) && at_end;
  end

endmodule

// File: rtl/mbt_portmux.sv
module mbt_portmux
  import mbt_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_active,
  input  logic              eng_en,
  input  logic              eng_we,
  input  logic [AW-1:0]     eng_addr,
  input  logic [BYTE_W-1:0] eng_wdata,
  input  logic              f_valid,
  input  logic              f_we,
  input  logic [AW-1:0]     f_addr,
  input  logic [BYTE_W-1:0] f_wdata,
  output logic              f_ready,
  output logic              f_rvalid,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [BYTE_W-1:0] ram_wdata
);

  always_comb begin
    f_ready = !eng_active;
    if (eng_active) begin
      ram_en    = eng_en;
      ram_we    = eng_we;
      ram_addr  = eng_addr;
      ram_wdata = eng_wdata;
    end else begin
      ram_en    = f_valid;
      ram_we    = f_valid && f_we;
      ram_addr  = f_addr;
      ram_wdata = f_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_rvalid <= 1'b0;
    end else begin
      f_rvalid <= f_valid && !eng_active && !f_we;
    end
  end

endmodule

// File: rtl/mem_bg_tester.sv
module mem_bg_tester
  import mbt_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned IW          = 16,
  parameter int unsigned RANGE_FIRST = 0,
  parameter int unsigned RANGE_LAST  = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [IW-1:0]     interval,
  input  logic              err_clr,
  input  logic              f_valid,
  output logic              f_ready,
  input  logic              f_we,
  input  logic [AW-1:0]     f_addr,
  input  logic [7:0]        f_wdata,
  output logic              f_rvalid,
  output logic [7:0]        f_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [AW-1:0]     ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              err_flag,
  output logic [AW-1:0]     err_addr,
  output logic [1:0]        err_pat,
  output logic              pass_done
);

  logic              eng_active;
  logic              eng_en;
  logic              eng_we;
  logic [AW-1:0]     eng_addr;
  logic [BYTE_W-1:0] eng_wdata;
  logic              due;
  logic              start;

  assign start   = due && enable && !f_valid && !eng_active;
  assign f_rdata = ram_rdata;

  mbt_timer #(.IW(IW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (enable && !eng_active),
    .interval (interval),
    .due      (due)
  );

  mbt_engine #(.AW(AW), .FIRST(RANGE_FIRST), .LAST(RANGE_LAST)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_data   (ram_rdata),
    .err_clr   (err_clr),
    .active    (eng_active),
    .m_en      (eng_en),
    .m_we      (eng_we),
    .m_addr    (eng_addr),
    .m_wdata   (eng_wdata),
    .err_flag  (err_flag),
    .err_addr  (err_addr),
    .err_pat   (err_pat),
    .pass_done (pass_done)
  );

  mbt_portmux #(.AW(AW)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_active (eng_active),
    .eng_en     (eng_en),
    .eng_we     (eng_we),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .f_valid    (f_valid),
    .f_we       (f_we),
    .f_addr     (f_addr),
    .f_wdata    (f_wdata),
    .f_ready    (f_ready),
    .f_rvalid   (f_rvalid),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata)
  );

endmodule

// File: rtl/mbt_checker.sv
module mbt_checker
  import mbt_pkg::*;
#(
  parameter int unsigned AW    = 8,
  parameter int unsigned FIRST = 0,
  parameter int unsigned LAST  = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          err_clr,
  input logic          f_valid,
  input logic          f_ready,
  input logic          f_we,
  input logic          f_rvalid,
  input logic          ram_en,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          err_flag,
  input logic          pass_done
);

  logic [4:0] lowcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowcnt <= '0;
    else if (f_ready)  lowcnt <= '0;
    else               lowcnt <= lowcnt + 5'd1;
  end

  AST_RANGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!f_ready && ram_en) |-> (int'(ram_addr) >= int'(FIRST) && int'(ram_addr) <= int'(LAST))); // R1
  AST_STEP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_ready) |-> ($past(lowcnt) == 5'(STEP_CYCLES - 1))); // R2
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !f_ready |-> (lowcnt < 5'(STEP_CYCLES))); // R10
  AST_SAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_ready) |-> (ram_en && !ram_we)); // R3
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(f_ready) |-> ($past(enable) && !$past(f_valid))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && f_ready) |=> !err_flag); // R7
  AST_RVALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    f_rvalid |-> $past(f_valid && f_ready && !f_we)); // R9
  AST_PASS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> (ram_en && ram_we && !f_ready && int'(ram_addr) == int'(LAST))); // R11

endmodule

bind mem_bg_tester mbt_checker #(.AW(AW), .FIRST(RANGE_FIRST), .LAST(RANGE_LAST)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .err_clr   (err_clr),
  .f_valid   (f_valid),
  .f_ready   (f_ready),
  .f_we      (f_we),
  .f_rvalid  (f_rvalid),
  .ram_en    (ram_en),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .err_flag  (err_flag),
  .pass_done (pass_done)
);

// File: tb/sim_mem_bg_tester.sv
module sim_mem_bg_tester;

  localparam int AW    = 6;
  localparam int IW    = 8;
  localparam int FIRST = 4;
  localparam int LAST  = 19;
  localparam int DEPTH = 1 << AW;
  localparam int FA    = 7;   // stuck-at-1 on bit 3
  localparam int FB    = 12;  // stuck-at-0 on bit 0

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic [IW-1:0] interval;
  logic          err_clr;
  logic          f_valid;
  logic          f_ready;
  logic          f_we;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_wdata;
  logic          f_rvalid;
  logic [7:0]    f_rdata;
  logic          ram_en;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;
  logic [7:0]    ram_rdata;
  logic          err_flag;
  logic [AW-1:0] err_addr;
  logic [1:0]    err_pat;
  logic          pass_done;

  always #10 clk = ~clk;  // 50 MHz

  mem_bg_tester #(.AW(AW), .IW(IW), .RANGE_FIRST(FIRST), .RANGE_LAST(LAST)) u0 (.*);

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mem     [DEPTH];
  logic [7:0] ref_mem [DEPTH];
  bit fault_a = 0;
  bit fault_b = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] patv(input int p);
    case (p)
      0: return 8'h00;
      1: return 8'hFF;
      2: return 8'hAA;
      default: return 8'h55;
    endcase
  endfunction

  // RAM model with one-cycle read latency and injectable faults
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= (mem[ram_addr] | ((fault_a && ram_addr == AW'(FA)) ? 8'h08 : 8'h00))
                   & ~((fault_b && ram_addr == AW'(FB)) ? 8'h01 : 8'h00);
    end
  end

  // traffic / disable marker for gap checks
  int dirty_cnt = 0;
  always @(posedge clk) if (f_valid || !enable) dirty_cnt++;

  // step monitor
  int run = 0, gap = 0, dirty_mark = 0, steps_done = 0, passes = 0;
  bit have_prev = 0;
  int exp_addr = FIRST;
  int tested_cnt [DEPTH];
  bit op_en [16];
  bit op_we [16];
  bit op_pd [16];
  int op_a  [16];
  int op_d  [16];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!f_ready) begin
        if (run == 0) begin
          if (have_prev && dirty_cnt == dirty_mark)
            chk(gap == int'(interval) + 1, "R8 step gap", gap, int'(interval) + 1);
        end
        if (run < 16) begin
          op_en[run] = ram_en; op_we[run] = ram_we; op_pd[run] = pass_done;
          op_a[run] = int'(ram_addr); op_d[run] = int'(ram_wdata);
        end
        run++;
      end else begin
        if (run > 0) begin
          chk(run == 15, "R2 step length", run, 15);
          if (run == 15) begin
            int a;
            a = op_a[0];
            chk(a == exp_addr, "R1 step address", a, exp_addr);
            chk(op_en[0] && !op_we[0], "R3 save read first", {op_en[0], op_we[0]}, 2);
            for (int p = 0; p < 4; p++) begin
              chk(op_en[2+3*p] && op_we[2+3*p] && op_a[2+3*p] == a && op_d[2+3*p] == int'(patv(p)),
                  "R4 pattern write", op_d[2+3*p], int'(patv(p)));
              chk(op_en[3+3*p] && !op_we[3+3*p] && op_a[3+3*p] == a,
                  "R4 readback", {op_en[3+3*p], op_we[3+3*p]}, 2);
            end
            chk(op_en[14] && op_we[14] && op_a[14] == a && op_d[14] == int'(ref_mem[a]),
                "R5 restore value", op_d[14], int'(ref_mem[a]));
            for (int k = 0; k < 14; k++)
              if (op_pd[k]) chk(0, "R11 stray pass pulse", k, 14);
            chk(op_pd[14] == (a == LAST), "R11 pass pulse", op_pd[14], (a == LAST));
            if (a == LAST) passes++;
            exp_addr = (a == LAST) ? FIRST : a + 1;
            tested_cnt[a]++;
          end
          steps_done++;
          have_prev = 1;
          gap = 0;
          dirty_mark = dirty_cnt;
        end
        run = 0;
        gap++;
      end
    end
  end

  int stalls = 0;

  task automatic fop(input bit we, input int a, input logic [7:0] d);
    bit stalled;
    stalled = 0;
    f_valid = 1; f_we = we; f_addr = AW'(a); f_wdata = d;
    while (!f_ready) begin stalled = 1; @(negedge clk); end
    @(negedge clk);
    f_valid = 0;
    if (stalled) stalls++;
    if (we) ref_mem[a] = d;
    else chk(f_rvalid && f_rdata == ref_mem[a],
             stalled ? "R9 stalled read" : "R5 read data", int'(f_rdata), int'(ref_mem[a]));
  endtask

  task automatic wait_idle();
    while (!f_ready) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int s0, lows, c0;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
      tested_cnt[i] = 0;
    end
    rst_n = 0; enable = 0; interval = 3; err_clr = 0;
    f_valid = 0; f_we = 0; f_addr = '0; f_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(f_ready == 1, "R9 reset ready", f_ready, 1);
    chk(err_flag == 0, "R6 reset flag", err_flag, 0);
    chk(pass_done == 0, "R11 reset pass", pass_done, 0);
    chk(f_rvalid == 0, "R9 reset rvalid", f_rvalid, 0);
    repeat (30) @(negedge clk);
    chk(steps_done == 0, "R10 idle when disabled", steps_done, 0);

    // spacing with two interval settings
    enable = 1;
    while (steps_done < 4) @(negedge clk);
    enable = 0; wait_idle(); interval = 0; @(negedge clk); enable = 1;
    s0 = steps_done;
    while (steps_done < s0 + 4) @(negedge clk);

    // random traffic interleaved with steps
    enable = 0; wait_idle(); interval = 2; @(negedge clk); enable = 1;
    for (int i = 0; i < 700; i++) begin
      fop($urandom % 2, $urandom % DEPTH, 8'($urandom));
      repeat ($urandom % 4) @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      wait_idle();
      while (f_ready) @(negedge clk);
      fop(0, FIRST + i, 8'h00);
    end
    chk(stalls > 0, "R9 stalls observed", stalls, 1);
    chk(passes >= 1, "R11 wrap seen", passes, 1);

    // enable drop during a step
    while (f_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    enable = 0;
    s0 = steps_done;
    wait_idle();
    lows = 0;
    repeat (80) begin @(negedge clk); if (!f_ready) lows++; end
    chk(steps_done == s0 + 1, "R10 step finished", steps_done, s0 + 1);
    chk(lows == 0, "R10 no new step", lows, 0);

    // fault capture, no overwrite, clear, recapture
    fop(1, FA, 8'h0C);
    fop(1, FB, 8'h0C);
    fault_a = 1; interval = 0;
    @(negedge clk); enable = 1;
    c0 = tested_cnt[FA];
    while (tested_cnt[FA] == c0) @(negedge clk);
    chk(err_flag == 1, "R6 flag set", err_flag, 1);
    chk(err_addr == AW'(FA), "R6 capture addr", err_addr, FA);
    chk(err_pat == 2'd0, "R6 capture pattern", err_pat, 0);
    fault_b = 1;
    c0 = tested_cnt[FB];
    while (tested_cnt[FB] == c0) @(negedge clk);
    chk(err_flag == 1 && err_addr == AW'(FA), "R6 no overwrite addr", err_addr, FA);
    chk(err_pat == 2'd0, "R6 no overwrite pattern", err_pat, 0);
    enable = 0; wait_idle(); fault_a = 0;
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(err_flag == 0, "R7 flag cleared", err_flag, 1'b0);
    repeat (5) @(negedge clk);
    chk(err_flag == 0, "R7 stays clear", err_flag, 0);
    enable = 1;
    c0 = tested_cnt[FB];
    while (tested_cnt[FB] == c0) @(negedge clk);
    chk(err_flag == 1 && err_addr == AW'(FB), "R6 new capture addr", err_addr, FB);
    chk(err_pat == 2'd1, "R6 new capture pattern", err_pat, 1);
    enable = 0; wait_idle(); fault_b = 0;
    fop(0, FA, 8'h00);
    fop(0, FB, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule